// File: doc/BRIEF.md
# Fractional SCL Half-Period Tick Generator

This block derives the SCL timing of an I2C master from a faster kernel clock. Every kernel clock, while the generator runs, a remainder register gains a step value (the increment). When the sum reaches the modulus (the decrement), the modulus is subtracted and a single-cycle half-period tick is issued, which the bus engine uses to toggle SCL. The mean tick rate is the kernel clock times increment over modulus, so with an increment of one the modulus is the number of kernel clocks per SCL half period.

Two setting registers share one layout, one for standard speed and one for the fast mode, and a speed input picks the active one. Settings are written only while the run input is low and stay fixed while it is high. A setting whose modulus is below seven, or whose increment exceeds the modulus, is reported as invalid and yields no ticks. Control is a four-state machine: OFF (stopped, remainder zero), RUN (accumulating), SWAP (one cycle after a speed change, remainder zero) and FAULT (active setting invalid, no ticks). Transitions: OFF to RUN on run high with a valid setting, OFF to FAULT on run high with an invalid one; RUN to OFF on run low, RUN to SWAP on a speed change; SWAP to OFF, RUN or FAULT by the same run and validity tests; FAULT to OFF on run low and FAULT to SWAP on a speed change.

Top module: `fdiv_top`

## Requirements
- R1: After reset the tick output is low, both setting registers hold zero and the error output is high.
- R2: In a 32-bit setting word the increment occupies bits 26:16 and the modulus bits 10:0; all other bits are ignored.
- R3: With an increment of 1 and a valid modulus D, ticks are exactly D kernel clocks apart.
- R4: Counting from the first accumulating clock, after j clocks the number of ticks is floor(j*INC/DEC) and every gap between ticks is floor(DEC/INC) or ceil(DEC/INC) clocks.
- R5: A modulus below 7, or an increment above the modulus, raises the error output and yields no ticks while run is high.
- R6: speed_hi low selects the standard register and high selects the fast register; a speed change while running clears the remainder, the next clock issues no tick and accumulation resumes from zero one clock later.
- R7: A write (cfg_wr_en high; cfg_wr_fast picks the fast register when high) is taken only while run_en is low; a write while run_en is high leaves the setting unchanged.
- R8: run_en low stops the ticks on the next clock and clears the remainder, so a restart counts from zero.
- R9: An increment of 0 with a valid modulus is not an error and yields no ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Setting write strobe |
| cfg_wr_fast | input | 1 | Write target: 0 standard, 1 fast |
| cfg_wdata | input | 32 | Setting word |
| run_en | input | 1 | Generator enable |
| speed_hi | input | 1 | Active setting select |
| half_tick_o | output | 1 | One-cycle SCL half-period tick |
| cfg_err_o | output | 1 | Active setting invalid |

## Verification
The speed select can change in the very cycle in which the remainder would otherwise cross the modulus, so a restart and a tick compete for the same clock edge. The bench switches the speed while running and then counts ticks from the second following edge; a tick leaking through, or a remainder not cleared, moves the count away from the floor(j*INC/DEC) value. A write arriving in a cycle where run is high competes with accumulation in the same way and is judged by the tick count before and after a restart.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_SWAP  = 2'd2,
        ST_FAULT = 2'd3
    } fdiv_state_t;
endpackage

// File: rtl/fdiv_cfg_bank.sv
module fdiv_cfg_bank #(
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_fast,
    input  logic [CFG_W-1:0] wdata,
    input  logic             run_en,
    output logic [CFG_W-1:0] norm_q,
    output logic [CFG_W-1:0] fast_q
);
    logic [1:0]            wr_hit;
    logic [CFG_W-1:0]      bank_q [2];

    assign wr_hit[0] = wr_en && !run_en && !wr_fast;
    assign wr_hit[1] = wr_en && !run_en &&  wr_fast;

    for (genvar b = 0; b < 2; b++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank_q[b] <= '0;
            else if (wr_hit[b])
                bank_q[b] <= wdata;
        end
    end

    assign norm_q = bank_q[0];
    assign fast_q = bank_q[1];
endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
    import fdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_en,
    input  logic        speed_hi,
    input  logic        cfg_bad,
    output fdiv_state_t state_o,
    output logic        advance_o
);
    fdiv_state_t state_q, state_d;
    logic        speed_q;
    logic        speed_moved;

    assign speed_moved = (speed_hi != speed_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            speed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            speed_q <= speed_hi;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_en) state_d = cfg_bad ? ST_FAULT : ST_RUN;
            end
            ST_RUN: begin
                if (!run_en)          state_d = ST_OFF;
                else if (speed_moved) state_d = ST_SWAP;
            end
            ST_SWAP: begin
                if (!run_en)          state_d = ST_OFF;
                else if (speed_moved) state_d = ST_SWAP;
                else if (cfg_bad)     state_d = ST_FAULT;
                else                  state_d = ST_RUN;
            end
            ST_FAULT: begin
                if (!run_en)          state_d = ST_OFF;
                else if (speed_moved) state_d = ST_SWAP;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        advance_o = 1'b0;
        unique case (state_q)
            ST_RUN:   advance_o = run_en && !speed_moved;
            ST_OFF,
            ST_SWAP,
            ST_FAULT: advance_o = 1'b0;
            default:  advance_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
    parameter int INC_W = 11,
    parameter int DEC_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [INC_W-1:0] inc,
    input  logic [DEC_W-1:0] dec,
    output logic [DEC_W:0]   acc_o,
    output logic             tick_o
);
    localparam int ACC_W = DEC_W + 1;
    localparam int SUM_W = ((INC_W > DEC_W) ? INC_W : DEC_W) + 2;

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] dec_ext;
    logic             wrap;

    assign sum     = SUM_W'(acc_q) + SUM_W'(inc);
    assign dec_ext = SUM_W'(dec);
    assign wrap    = (sum >= dec_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (!advance) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (wrap) begin
            acc_q  <= ACC_W'(sum - dec_ext);
            tick_o <= 1'b1;
        end else begin
            acc_q  <= ACC_W'(sum);
            tick_o <= 1'b0;
        end
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
    import fdiv_pkg::*;
#(
    parameter int CFG_W   = 32,
    parameter int INC_LSB = 16,
    parameter int INC_W   = 11,
    parameter int DEC_LSB = 0,
    parameter int DEC_W   = 11,
    parameter int MIN_DEC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic             cfg_wr_fast,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             run_en,
    input  logic             speed_hi,
    output logic             half_tick_o,
    output logic             cfg_err_o
);
    logic [CFG_W-1:0] norm_q, fast_q;
    logic [CFG_W-1:0] words [2];
    logic [INC_W-1:0] inc_f [2];
    logic [DEC_W-1:0] dec_f [2];
    logic [1:0]       bad_f;
    logic [INC_W-1:0] inc_act;
    logic [DEC_W-1:0] dec_act;
    logic             bad_act;
    logic             advance;
    logic [DEC_W:0]   acc_val;
    fdiv_state_t      state;

    fdiv_cfg_bank #(.CFG_W(CFG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_fast (cfg_wr_fast),
        .wdata   (cfg_wdata),
        .run_en  (run_en),
        .norm_q  (norm_q),
        .fast_q  (fast_q)
    );

    assign words[0] = norm_q;
    assign words[1] = fast_q;

    for (genvar b = 0; b < 2; b++) begin : g_field
        assign inc_f[b] = words[b][INC_LSB +: INC_W];
        assign dec_f[b] = words[b][DEC_LSB +: DEC_W];
        assign bad_f[b] = (dec_f[b] < DEC_W'(MIN_DEC)) ||
                          (DEC_W'(inc_f[b]) > dec_f[b]);
    end

    assign inc_act = speed_hi ? inc_f[1] : inc_f[0];
    assign dec_act = speed_hi ? dec_f[1] : dec_f[0];
    assign bad_act = speed_hi ? bad_f[1] : bad_f[0];

    fdiv_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .speed_hi  (speed_hi),
        .cfg_bad   (bad_act),
        .state_o   (state),
        .advance_o (advance)
    );

    fdiv_accum #(.INC_W(INC_W), .DEC_W(DEC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .inc     (inc_act),
        .dec     (dec_act),
        .acc_o   (acc_val),
        .tick_o  (half_tick_o)
    );

    assign cfg_err_o = bad_act;
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk #(
    parameter int CFG_W = 32,
    parameter int DEC_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             speed_hi,
    input logic             tick,
    input logic             cfg_err,
    input logic [DEC_W:0]   acc,
    input logic [DEC_W-1:0] dec,
    input logic [CFG_W-1:0] norm_q,
    input logic [CFG_W-1:0] fast_q
);
    // R5
    err_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !tick);

    // R8
    off_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !tick);

    // R4
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && !cfg_err && (speed_hi == $past(speed_hi)) |-> (acc < {1'b0, dec}));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> $stable(norm_q) && $stable(fast_q));

    // R6
    swap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && (speed_hi != $past(speed_hi)) |=> !tick);
endmodule

bind fdiv_top fdiv_chk #(.CFG_W(CFG_W), .DEC_W(DEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .speed_hi (speed_hi),
    .tick     (half_tick_o),
    .cfg_err  (cfg_err_o),
    .acc      (acc_val),
    .dec      (dec_act),
    .norm_q   (norm_q),
    .fast_q   (fast_q)
);

// File: tb/sim_fdiv_top.sv
`timescale 1ns/1ps
module sim_fdiv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_fast = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        run_en = 1'b0;
    logic        speed_hi = 1'b0;
    logic        half_tick_o;
    logic        cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fdiv_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_fast (cfg_wr_fast),
        .cfg_wdata   (cfg_wdata),
        .run_en      (run_en),
        .speed_hi    (speed_hi),
        .half_tick_o (half_tick_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int inc, input int dec);
        return (32'(inc) << 16) | 32'(dec);
    endfunction

    task automatic wr(input logic fast, input logic [31:0] w);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_fast = fast; cfg_wdata = w;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // counts ticks over m edges; gaps checked against [lo,hi] when lo > 0
    task automatic count(input int m, input int lo, input int hi,
                         output int n, output int gap_err);
        int last = -1;
        n = 0; gap_err = 0;
        for (int i = 0; i < m; i++) begin
            @(posedge clk); @(negedge clk);
            if (half_tick_o) begin
                if (last >= 0 && lo > 0 && ((i - last) < lo || (i - last) > hi))
                    gap_err++;
                last = i;
                n++;
            end
        end
    endtask

    task automatic start_run;
        @(negedge clk);
        run_en = 1'b1;
        @(posedge clk);
    endtask

    task automatic stop_run;
        @(negedge clk);
        run_en = 1'b0;
        @(posedge clk); @(posedge clk);
    endtask

    initial begin
        int n, g;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tick", int'(half_tick_o), 0);
        check("R1 err", int'(cfg_err_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 err after release", int'(cfg_err_o), 1);

        // R3 R4 sweep
        for (int d = 7; d <= 12; d++) begin
            for (int inc = 1; inc <= d; inc++) begin
                wr(1'b0, word(inc, d));
                check("R4 err low", int'(cfg_err_o), 0);
                start_run();
                count(60, d / inc, (d + inc - 1) / inc, n, g);
                if (inc == 1) check("R3 count", n, 60 / d);
                else          check("R4 count", n, (60 * inc) / d);
                check(inc == 1 ? "R3 gap" : "R4 gap", g, 0);
                stop_run();
            end
        end

        // R2 bits outside fields ignored
        wr(1'b0, 32'hF800_F800 | word(3, 10));
        check("R2 err", int'(cfg_err_o), 0);
        start_run();
        count(50, 3, 4, n, g);
        check("R2 count", n, 15);
        stop_run();

        // R5 invalid modulus
        for (int d = 0; d <= 6; d++) begin
            wr(1'b0, word(1, d));
            check("R5 err", int'(cfg_err_o), 1);
            start_run();
            count(20, 0, 0, n, g);
            check("R5 no tick", n, 0);
            stop_run();
        end
        wr(1'b0, word(9, 8));
        check("R5 inc above dec err", int'(cfg_err_o), 1);
        start_run();
        count(20, 0, 0, n, g);
        check("R5 inc above dec ticks", n, 0);
        stop_run();

        // R9 zero increment
        wr(1'b0, word(0, 8));
        check("R9 err", int'(cfg_err_o), 0);
        start_run();
        count(30, 0, 0, n, g);
        check("R9 no tick", n, 0);
        stop_run();

        // R7 write during run ignored
        wr(1'b0, word(1, 8));
        start_run();
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_fast = 1'b0; cfg_wdata = word(1, 10);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        stop_run();
        start_run();
        count(40, 8, 8, n, g);
        check("R7 count after ignored write", n, 5);
        stop_run();

        // R8 restart from zero
        wr(1'b0, word(1, 10));
        start_run();
        count(7, 0, 0, n, g);
        check("R8 partial", n, 0);
        stop_run();
        check("R8 tick low when stopped", int'(half_tick_o), 0);
        start_run();
        count(9, 0, 0, n, g);
        check("R8 restart early", n, 0);
        count(1, 0, 0, n, g);
        check("R8 restart tick", n, 1);
        stop_run();

        // R6 speed select and swap
        wr(1'b0, word(1, 8));
        wr(1'b1, word(1, 12));
        start_run();
        count(13, 0, 0, n, g);
        check("R6 standard count", n, 1);
        @(negedge clk);
        speed_hi = 1'b1;
        @(posedge clk); @(posedge clk);
        count(48, 12, 12, n, g);
        check("R6 fast count", n, 4);
        check("R6 fast gap", g, 0);
        stop_run();
        wr(1'b1, word(1, 5));
        check("R6 fast err", int'(cfg_err_o), 1);
        @(negedge clk);
        speed_hi = 1'b0;
        @(negedge clk);
        check("R6 standard err", int'(cfg_err_o), 0);
        start_run();
        count(5, 0, 0, n, g);
        @(negedge clk);
        speed_hi = 1'b1;
        count(30, 0, 0, n, g);
        check("R6 swap to invalid", n, 0);
        check("R6 swap err", int'(cfg_err_o), 1);
        stop_run();

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule